// File: doc/BRIEF.md
# Audio Subsystem Clock Tree Controller

This block turns a handful of free-running tick inputs into the clock enables of an audio subsystem. Everything runs on one fast system clock. Each "clock" here is a single-cycle enable pulse, and software shapes those pulses through three 32-bit registers. The source register picks the origin of the main audio clock and of the I2S clock. The divider register holds three 4-bit ratios. The gate register turns each output on or off.

There are three dividers. The DSP divider divides the main audio source. The bus divider divides the DSP divider's output rather than a source, so the two form a cascade. The I2S divider divides the selected I2S source. Gated outputs feed the DSP core, the I2S bus and bit timing, and the PCM bus and bit timing. The PCM pair is derived from a PCM tick that is divided outside the block. A build-time parameter decides what gate bit 1 does: it either gates an internal-memory enable or is a reserved bit whose stored value writes cannot change.

Top module: `audio_clk_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all three registers read 0, every divider ratio is taken as 0, and all six enable outputs are 0.
- R2: Registers are decoded by byte address on aligned addresses only: source at 0x0, divider at 0x4, gate at 0x8. An access to 0xC, or to any address whose two low bits are not 0, reads 0 and is not written. Source bits other than 0 and [3:2], divider bits above 11, and gate bits above 5 read 0 and ignore writes. Reads are combinational. A write lands on the rising edge where `bus_wr` is 1.
- R3: Source bit 0 selects the main audio source: 0 takes `osc_tick`, 1 takes `pll_tick`.
- R4: Source bits [3:2] select the I2S source: 0 takes the main audio source, 1 takes `codec_tick`, 2 takes `ext_aud_tick`, and 3 takes nothing, so the I2S path then produces no pulses.
- R5: A ratio field value N makes its divider emit one pulse per N+1 input pulses, and the pulse coincides with an input pulse; N=0 passes every input pulse. Divider bits [3:0] divide the main source (DSP). Bits [7:4] divide the DSP divider's ungated output (bus). Bits [11:8] divide the I2S source.
- R6: A new ratio value takes effect only after the divider's current count reaches its terminal count. Until then the old ratio sets the period, so no period is shortened.
- R7: Gate bits enable outputs when 1 and hold them at 0 when 0: bit 0 drives `dsp_clk_en`, bit 2 drives `i2s_bus_en` (from the bus divider), and bit 3 drives `i2s_bit_en` (from the I2S divider). Each output is registered and rises in the cycle after the rising edge that samples the input pulse.
- R8: `pcm_bit_en` is `pcm_div_tick` gated by gate bit 5. `pcm_bus_en` is that gated bit pulse further gated by bit 4. Both are registered like R7.
- R9: With `HAS_MEM_GATE`=1, gate bit 1 is writable and gates the DSP divider output onto `mem_clk_en`. With `HAS_MEM_GATE`=0, writes leave bit 1 at its stored (reset) value 0, it reads 0, and `mem_clk_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W (4) | Byte address of the register access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| osc_tick | input | 1 | Reference oscillator enable pulse |
| pll_tick | input | 1 | Audio PLL enable pulse |
| codec_tick | input | 1 | External codec clock enable pulse |
| ext_aud_tick | input | 1 | Audio clock enable from outside the subsystem |
| pcm_div_tick | input | 1 | Externally divided PCM enable pulse |
| dsp_clk_en | output | 1 | Gated DSP core enable |
| mem_clk_en | output | 1 | Gated internal-memory enable (variant dependent) |
| i2s_bus_en | output | 1 | Gated I2S bus enable |
| i2s_bit_en | output | 1 | Gated I2S bit enable |
| pcm_bus_en | output | 1 | Gated PCM bus enable |
| pcm_bit_en | output | 1 | Gated PCM bit enable |

## Verification
The bench first steps each selector through all of its codes while the tick inputs pulse on different cycles. An output that follows the wrong input therefore shows up in the timing of its pulses. A continuous tick with ratios of 0, 2 and 7 separates a divide-by-N from a divide-by-N+1 and shows whether the bus divider is fed by the DSP divider or by the source. A ratio rewrite in the middle of a count reveals any divider that picks up the new value before its terminal count. Random mixes of ticks, register writes (including unmapped and misaligned addresses) and reads are then run through two instances, one of each bit-1 variant, and compared cycle by cycle with a model built from the requirements.

// File: rtl/acs_pkg.sv
// Shared constants for the audio clock tree controller: register word
// indices, field positions and gate bit assignments.
package acs_pkg;
    localparam int WORD_LSB   = 2;     // byte address bits below the word index
    localparam int IDX_SRC    = 0;     // source select word (byte 0x0)
    localparam int IDX_DIV    = 1;     // divider ratio word (byte 0x4)
    localparam int IDX_GATE   = 2;     // gate enable word   (byte 0x8)

    localparam int SRC_MAIN_BIT = 0;   // main source select bit
    localparam int SRC_I2S_LSB  = 2;   // I2S source select field [3:2]
    localparam int SRC_I2S_W    = 2;

    localparam int GATE_W       = 6;
    localparam int G_DSP        = 0;
    localparam int G_MEM        = 1;
    localparam int G_I2S_BUS    = 2;
    localparam int G_I2S_BIT    = 3;
    localparam int G_PCM_BUS    = 4;
    localparam int G_PCM_BIT    = 5;

    typedef enum logic [SRC_I2S_W-1:0] {
        I2S_FROM_MAIN  = 2'd0,
        I2S_FROM_CODEC = 2'd1,
        I2S_FROM_EXT   = 2'd2,
        I2S_FROM_NONE  = 2'd3
    } i2s_src_e;
endpackage

// File: rtl/acs_regbank.sv
// Register bank: decodes aligned byte addresses into three words, keeps only
// the defined fields, and returns them on a combinational read path.
// Assumes single-cycle writes; unmapped or misaligned accesses do nothing.
module acs_regbank
    import acs_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 32,
    parameter int RW           = 4,
    parameter bit HAS_MEM_GATE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 main_sel,
    output logic [SRC_I2S_W-1:0] i2s_sel,
    output logic [RW-1:0]        dsp_ratio,
    output logic [RW-1:0]        bus_ratio,
    output logic [RW-1:0]        i2s_ratio,
    output logic [GATE_W-1:0]    gate
);
    localparam int WORD_W = ADDR_W - WORD_LSB;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              hit_src, hit_div, hit_gate;
    logic              wdata_unused;

    assign word     = addr[ADDR_W-1:WORD_LSB];
    assign aligned  = (addr[WORD_LSB-1:0] == '0);
    assign hit_src  = aligned && (int'(word) == IDX_SRC);
    assign hit_div  = aligned && (int'(word) == IDX_DIV);
    assign hit_gate = aligned && (int'(word) == IDX_GATE);
    assign wdata_unused = ^wdata;

    // Source select and divider ratio storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_sel  <= 1'b0;
            i2s_sel   <= '0;
            dsp_ratio <= '0;
            bus_ratio <= '0;
            i2s_ratio <= '0;
        end else if (wr_en) begin
            if (hit_src) begin
                main_sel <= wdata[SRC_MAIN_BIT];
                i2s_sel  <= wdata[SRC_I2S_LSB +: SRC_I2S_W];
            end
            if (hit_div) begin
                dsp_ratio <= wdata[0 +: RW];
                bus_ratio <= wdata[RW +: RW];
                i2s_ratio <= wdata[2*RW +: RW];
            end
        end
    end

    // Gate storage; bit 1 is writable only in the memory-gate variant.
    for (genvar g = 0; g < GATE_W; g++) begin : g_gate
        if (g != G_MEM || HAS_MEM_GATE) begin : g_rw
            // Writable gate bit.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    gate[g] <= 1'b0;
                else if (wr_en && hit_gate)
                    gate[g] <= wdata[g];
            end
        end else begin : g_reserved
            // Reserved bit keeps its reset value whatever is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    gate[g] <= 1'b0;
            end
        end
    end

    // Combinational readback of the addressed word with undefined bits at 0.
    always_comb begin
        rdata = '0;
        if (hit_src) begin
            rdata[SRC_MAIN_BIT]               = main_sel;
            rdata[SRC_I2S_LSB +: SRC_I2S_W]   = i2s_sel;
        end
        if (hit_div)
            rdata[3*RW-1:0] = {i2s_ratio, bus_ratio, dsp_ratio};
        if (hit_gate)
            rdata[GATE_W-1:0] = gate;
    end
endmodule

// File: rtl/acs_src_sel.sv
// Source selection: picks the main audio enable stream and the I2S enable
// stream from the tick inputs. Purely combinational; code 3 on the I2S
// select yields no pulses.
module acs_src_sel
    import acs_pkg::*;
(
    input  logic                 osc_tick,
    input  logic                 pll_tick,
    input  logic                 codec_tick,
    input  logic                 ext_tick,
    input  logic                 main_sel,
    input  logic [SRC_I2S_W-1:0] i2s_sel,
    output logic                 main_en,
    output logic                 i2s_en
);
    // Main source mux.
    assign main_en = main_sel ? pll_tick : osc_tick;

    // I2S source mux including the empty code.
    always_comb begin
        unique case (i2s_src_e'(i2s_sel))
            I2S_FROM_MAIN:  i2s_en = main_en;
            I2S_FROM_CODEC: i2s_en = codec_tick;
            I2S_FROM_EXT:   i2s_en = ext_tick;
            default:        i2s_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/acs_divider.sv
// Enable-pulse divider: emits one pulse per (ratio+1) input pulses, in the
// same cycle as the input pulse that completes the count. The programmed
// ratio is loaded only at terminal count, so a period is never cut short.
module acs_divider #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_en,
    input  logic [RW-1:0] ratio,
    output logic          out_en
);
    logic [RW-1:0] cnt_q;
    logic [RW-1:0] act_q;

    assign out_en = in_en && (cnt_q == act_q);

    // Count input pulses; reload counter and active ratio at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (in_en) begin
            if (cnt_q == act_q) begin
                cnt_q <= '0;
                act_q <= ratio;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/acs_gate_out.sv
// Output gating: ANDs each divided stream with its gate bit and registers
// the result, one flop per enable output. The PCM bus enable is taken from
// the gated PCM bit enable. The memory enable exists only in that variant.
module acs_gate_out
    import acs_pkg::*;
#(
    parameter bit HAS_MEM_GATE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dsp_pulse,
    input  logic              bus_pulse,
    input  logic              i2s_pulse,
    input  logic              pcm_tick,
    input  logic [GATE_W-1:0] gate,
    output logic              dsp_clk_en,
    output logic              mem_clk_en,
    output logic              i2s_bus_en,
    output logic              i2s_bit_en,
    output logic              pcm_bus_en,
    output logic              pcm_bit_en
);
    logic pcm_bit_gated;

    assign pcm_bit_gated = pcm_tick && gate[G_PCM_BIT];

    // Register the always-present gated enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsp_clk_en <= 1'b0;
            i2s_bus_en <= 1'b0;
            i2s_bit_en <= 1'b0;
            pcm_bit_en <= 1'b0;
            pcm_bus_en <= 1'b0;
        end else begin
            dsp_clk_en <= dsp_pulse && gate[G_DSP];
            i2s_bus_en <= bus_pulse && gate[G_I2S_BUS];
            i2s_bit_en <= i2s_pulse && gate[G_I2S_BIT];
            pcm_bit_en <= pcm_bit_gated;
            pcm_bus_en <= pcm_bit_gated && gate[G_PCM_BUS];
        end
    end

    if (HAS_MEM_GATE) begin : g_mem
        // Register the internal-memory enable.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_clk_en <= 1'b0;
            else
                mem_clk_en <= dsp_pulse && gate[G_MEM];
        end
    end else begin : g_no_mem
        logic mem_gate_unused;
        assign mem_gate_unused = gate[G_MEM];
        assign mem_clk_en      = 1'b0;
    end
endmodule

// File: rtl/audio_clk_ctrl.sv
// Audio subsystem clock tree controller top: register bank, source muxes,
// three enable dividers (DSP, cascaded bus, I2S) and registered gates.
// Assumes all tick inputs are single-cycle pulses synchronous to clk.
module audio_clk_ctrl
    import acs_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 32,
    parameter int RW           = 4,
    parameter bit HAS_MEM_GATE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              osc_tick,
    input  logic              pll_tick,
    input  logic              codec_tick,
    input  logic              ext_aud_tick,
    input  logic              pcm_div_tick,
    output logic              dsp_clk_en,
    output logic              mem_clk_en,
    output logic              i2s_bus_en,
    output logic              i2s_bit_en,
    output logic              pcm_bus_en,
    output logic              pcm_bit_en
);
    logic                 main_sel_q;
    logic [SRC_I2S_W-1:0] i2s_sel_q;
    logic [RW-1:0]        dsp_ratio_q, bus_ratio_q, i2s_ratio_q;
    logic [GATE_W-1:0]    gate_q;
    logic                 main_en, i2s_en;
    logic                 dsp_pulse, bus_pulse, i2s_pulse;

    acs_regbank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RW(RW), .HAS_MEM_GATE(HAS_MEM_GATE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .main_sel(main_sel_q),
        .i2s_sel(i2s_sel_q), .dsp_ratio(dsp_ratio_q), .bus_ratio(bus_ratio_q),
        .i2s_ratio(i2s_ratio_q), .gate(gate_q)
    );

    acs_src_sel u_src (
        .osc_tick(osc_tick), .pll_tick(pll_tick), .codec_tick(codec_tick),
        .ext_tick(ext_aud_tick), .main_sel(main_sel_q), .i2s_sel(i2s_sel_q),
        .main_en(main_en), .i2s_en(i2s_en)
    );

    acs_divider #(.RW(RW)) u_div_dsp (
        .clk(clk), .rst_n(rst_n), .in_en(main_en), .ratio(dsp_ratio_q),
        .out_en(dsp_pulse)
    );

    acs_divider #(.RW(RW)) u_div_bus (
        .clk(clk), .rst_n(rst_n), .in_en(dsp_pulse), .ratio(bus_ratio_q),
        .out_en(bus_pulse)
    );

    acs_divider #(.RW(RW)) u_div_i2s (
        .clk(clk), .rst_n(rst_n), .in_en(i2s_en), .ratio(i2s_ratio_q),
        .out_en(i2s_pulse)
    );

    acs_gate_out #(.HAS_MEM_GATE(HAS_MEM_GATE)) u_gate (
        .clk(clk), .rst_n(rst_n), .dsp_pulse(dsp_pulse), .bus_pulse(bus_pulse),
        .i2s_pulse(i2s_pulse), .pcm_tick(pcm_div_tick), .gate(gate_q),
        .dsp_clk_en(dsp_clk_en), .mem_clk_en(mem_clk_en),
        .i2s_bus_en(i2s_bus_en), .i2s_bit_en(i2s_bit_en),
        .pcm_bus_en(pcm_bus_en), .pcm_bit_en(pcm_bit_en)
    );
endmodule

// File: rtl/acs_checker.sv
// Property checker for audio_clk_ctrl, attached to every instance by bind.
module acs_checker
    import acs_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [SRC_I2S_W-1:0] i2s_sel_q,
    input logic [GATE_W-1:0]    gate_q,
    input logic                 dsp_clk_en,
    input logic                 mem_clk_en,
    input logic                 i2s_bit_en,
    input logic                 pcm_bus_en,
    input logic                 pcm_bit_en
);
    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr[WORD_LSB-1:0] != '0) || (int'(bus_addr[ADDR_W-1:WORD_LSB]) > IDX_GATE))
        |-> (bus_rdata == '0)); // R2

    AST_SRC_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata[DATA_W-1:4] == '0 && !bus_rdata[1])); // R2

    AST_I2S_NONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (i2s_sel_q == 2'd3) |=> !i2s_bit_en); // R4

    AST_DSP_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q[G_DSP] |=> !dsp_clk_en); // R7

    AST_PCM_BUS_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_bus_en |-> pcm_bit_en); // R8

    AST_MEM_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q[G_MEM] |=> !mem_clk_en); // R9
endmodule

bind audio_clk_ctrl acs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .i2s_sel_q(i2s_sel_q), .gate_q(gate_q), .dsp_clk_en(dsp_clk_en),
    .mem_clk_en(mem_clk_en), .i2s_bit_en(i2s_bit_en),
    .pcm_bus_en(pcm_bus_en), .pcm_bit_en(pcm_bit_en)
);

// File: tb/audio_clk_ctrl_tb.sv
// Self-checking bench: two instances (reserved bit-1 and memory-gate
// variants) driven by the same stimulus, compared every cycle with a
// requirement-level model.
module audio_clk_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        osc = 1'b0, pll = 1'b0, codec = 1'b0, ext = 1'b0, pcm = 1'b0;
    logic [31:0] rd_a, rd_b;
    logic [5:0]  out_a, out_b; // {pcm_bit, pcm_bus, i2s_bit, i2s_bus, mem, dsp}

    int n_checks = 0;
    int n_fail   = 0;
    bit checking = 1'b0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    audio_clk_ctrl #(.HAS_MEM_GATE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_a), .osc_tick(osc), .pll_tick(pll),
        .codec_tick(codec), .ext_aud_tick(ext), .pcm_div_tick(pcm),
        .dsp_clk_en(out_a[0]), .mem_clk_en(out_a[1]), .i2s_bus_en(out_a[2]),
        .i2s_bit_en(out_a[3]), .pcm_bus_en(out_a[4]), .pcm_bit_en(out_a[5])
    );

    audio_clk_ctrl #(.HAS_MEM_GATE(1'b1)) u_dut_mem (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_b), .osc_tick(osc), .pll_tick(pll),
        .codec_tick(codec), .ext_aud_tick(ext), .pcm_div_tick(pcm),
        .dsp_clk_en(out_b[0]), .mem_clk_en(out_b[1]), .i2s_bus_en(out_b[2]),
        .i2s_bit_en(out_b[3]), .pcm_bus_en(out_b[4]), .pcm_bit_en(out_b[5])
    );

    // ---------------- requirement-level model ----------------
    logic [31:0] m_src, m_div;
    logic [5:0]  m_gate_a, m_gate_b;
    logic [3:0]  m_cnt [3];
    logic [3:0]  m_act [3];
    logic [5:0]  e_a, e_b;

    function automatic logic [31:0] exp_rd(input logic [3:0] a, input logic [5:0] g);
        if (a[1:0] != 2'b00) return 32'h0;          // R2 misaligned
        case (a[3:2])
            2'd0:    return m_src;
            2'd1:    return m_div;
            2'd2:    return {26'h0, g};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic main_en, i2s_en, inp;
        logic [2:0] p;
        if (!rst_n) begin
            m_src = 0; m_div = 0; m_gate_a = 0; m_gate_b = 0; e_a = 0; e_b = 0;
            for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_act[i] = 0; end
        end else begin
            main_en = m_src[0] ? pll : osc;                       // R3
            case (m_src[3:2])                                     // R4
                2'd0: i2s_en = main_en;
                2'd1: i2s_en = codec;
                2'd2: i2s_en = ext;
                default: i2s_en = 1'b0;
            endcase
            for (int i = 0; i < 3; i++) begin                     // R5 R6
                inp  = (i == 0) ? main_en : (i == 1) ? p[0] : i2s_en;
                p[i] = inp && (m_cnt[i] == m_act[i]);
                if (inp) begin
                    if (p[i]) begin m_cnt[i] = 0; m_act[i] = m_div[4*i +: 4]; end
                    else m_cnt[i] = m_cnt[i] + 1;
                end
            end
            e_a = {pcm & m_gate_a[5], pcm & m_gate_a[5] & m_gate_a[4], p[2] & m_gate_a[3],
                   p[1] & m_gate_a[2], 1'b0, p[0] & m_gate_a[0]};
            e_b = {pcm & m_gate_b[5], pcm & m_gate_b[5] & m_gate_b[4], p[2] & m_gate_b[3],
                   p[1] & m_gate_b[2], p[0] & m_gate_b[1], p[0] & m_gate_b[0]};
            if (bus_wr && bus_addr[1:0] == 2'b00) begin           // R2 R9
                case (bus_addr[3:2])
                    2'd0: m_src = bus_wdata & 32'hD;
                    2'd1: m_div = bus_wdata & 32'hFFF;
                    2'd2: begin
                        m_gate_a = {bus_wdata[5:2], m_gate_a[1], bus_wdata[0]};
                        m_gate_b = bus_wdata[5:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    localparam string OUT_TAG [6] = '{"R3 R5 R6 R7 dsp_clk_en", "R9 mem_clk_en",
        "R5 R7 i2s_bus_en", "R4 R5 R7 i2s_bit_en", "R8 pcm_bus_en", "R8 pcm_bit_en"};

    // Compare every output of both instances against the model mid-cycle.
    always @(negedge clk) begin
        if (checking) begin
            for (int i = 0; i < 6; i++) begin
                chk({31'h0, out_a[i]}, {31'h0, e_a[i]}, {OUT_TAG[i], " (reserved variant)"});
                chk({31'h0, out_b[i]}, {31'h0, e_b[i]}, {OUT_TAG[i], " (memory variant)"});
            end
        end
    end

    // One cycle of stimulus, optionally with a read check of current state.
    task automatic step(input logic [4:0] ticks, input logic wr, input logic [3:0] a,
                        input logic [31:0] d, input logic rd, input string tag);
        @(negedge clk);
        {osc, pll, codec, ext, pcm} = ticks;
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        if (rd) begin
            #1;
            chk(rd_a, exp_rd(a, m_gate_a), {tag, " read (reserved variant)"});
            chk(rd_b, exp_rd(a, m_gate_b), {tag, " read (memory variant)"});
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        step(5'b0, 1'b1, a, d, 1'b0, "");
    endtask

    task automatic run(input int n, input logic [4:0] ticks);
        for (int i = 0; i < n; i++) step(ticks, 1'b0, 4'h0, 32'h0, 1'b0, "");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd20240517);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checking = 1'b1;

        // R1: reset values of every register and output.
        step(5'b0, 1'b0, 4'h0, 0, 1'b1, "R1 src");
        step(5'b0, 1'b0, 4'h4, 0, 1'b1, "R1 div");
        step(5'b0, 1'b0, 4'h8, 0, 1'b1, "R1 gate");
        chk({26'h0, out_a}, 32'h0, "R1 outputs");

        // R2 R9: all-ones writes to every word, unmapped and misaligned.
        for (int a = 0; a < 16; a++) begin
            wr_reg(a[3:0], 32'hFFFF_FFFF);
            for (int r = 0; r < 16; r += 4) step(5'b0, 1'b0, r[3:0], 0, 1'b1, "R2 R9");
        end
        wr_reg(4'h8, 32'h0);
        step(5'b0, 1'b0, 4'h8, 0, 1'b1, "R9 clear");
        wr_reg(4'h8, 32'h2);
        step(5'b0, 1'b0, 4'h8, 0, 1'b1, "R9 bit1 only");

        // R3 R5 R7: divide ratios 0, 2, 7 on a continuous oscillator tick.
        wr_reg(4'h8, 32'h3F);
        wr_reg(4'h0, 32'h0);
        wr_reg(4'h4, 32'h012);
        run(40, 5'b10000);
        wr_reg(4'h4, 32'h070);
        run(60, 5'b10000);
        // R3: switch main source to the PLL with a sparse PLL tick.
        wr_reg(4'h0, 32'h1);
        for (int i = 0; i < 60; i++) run(1, (i % 3 == 0) ? 5'b01000 : 5'b10000);

        // R6: rewrite the DSP ratio mid-count.
        wr_reg(4'h0, 32'h0);
        wr_reg(4'h4, 32'h007);
        run(11, 5'b10000);
        wr_reg(4'h4, 32'h000);
        run(20, 5'b10000);

        // R4: every I2S select code with distinct tick patterns.
        for (int s = 0; s < 4; s++) begin
            wr_reg(4'h0, {28'h0, s[1:0], 2'b00});
            wr_reg(4'h4, 32'h100);
            for (int i = 0; i < 30; i++) run(1, {i[0], 1'b0, i[1], i[2], 1'b0});
        end

        // R8: PCM gating combinations.
        for (int g = 0; g < 4; g++) begin
            wr_reg(4'h8, {26'h0, g[1:0], 4'hF});
            run(6, 5'b00001);
        end

        // Constrained random mix of ticks, writes and reads.
        for (int i = 0; i < 15000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[7:0] < 12)
                step(r[12:8], 1'b1, r[19:16], $urandom | ((r[20]) ? 32'h3D : 32'h0), 1'b0, "");
            else
                step(r[12:8], 1'b0, r[19:16], 32'h0, r[8 +: 8] < 40, "R2 R9 random");
        end

        done = 1'b1;
        checking = 1'b0;
        finish_run();
    end
endmodule